// File: doc/BRIEF.md
# Configuration Port Controller

This block holds the I/O-side access logic that firmware uses to set up a multi-function peripheral chip. The decode base comes from a strap input. While the hardware reset is held, the strap is followed, and its value at release selects one of two fixed bases. Firmware can move that base later by writing two configuration registers.

The base address is a write-only port. When the block is in run mode, this port only feeds a key detector. Two consecutive writes of 0x55 unlock configuration mode. Once unlocked, a write of 0xAA to the same port locks it again, and any other value written there selects a register index. The byte at base+1 is a read/write data port onto a small internal register file, and it is live only while configuration mode is active. All decodes are blocked while the address-enable qualifier is high.

Top module: `cfg_port_ctrl`

## Requirements
- R1: While rst_ni is low, the block enters run mode, the index is cleared and every register clears to 0x00. The base is 0x03F0 when strap_i is 0 and 0x0370 when it is 1. Registers 0x26 and 0x27 reset to the low and high byte of that base.
- R2: Two consecutive writes of 0x55 to the base address, made while in run mode, set cfg_mode_o high on the clock after the second write.
- R3: In run mode, any write to the base address with a value other than 0x55 returns the key detector to its start. 0x55, 0x11, 0x55 therefore leaves the block in run mode, and one further 0x55 unlocks it.
- R4: In configuration mode, a write of 0xAA to the base address returns the block to run mode and leaves the index unchanged.
- R5: In configuration mode, a write of any value other than 0xAA to the base address loads that value into the 8-bit index.
- R6: In configuration mode, a write to base+1 stores into the register selected by the index, and a read of base+1 returns that register. An index at or above NUM_REGS (64) reads 0x00, and writes to it are dropped.
- R7: In run mode, writes to base+1 are ignored, reads of base+1 return 0xFF, and writes to the base address do not change the index.
- R8: While aen_i is high, no port decodes. rdata_o is 0xFF, and writes change neither the key detector, the mode, the index nor the registers.
- R9: rdata_o is 0xFF in every cycle without a decoded data-port read, and this includes reads of the base address.
- R10: Register 0x26 holds the low byte of a new base and register 0x27 the high byte. The decode moves to {reg 0x27, reg 0x26} on the clock after the write to 0x27, and the old base then stops responding.
- R11: A relocated base is kept until the next reset, and that reset reloads the base from strap_i.
- R12: ldev_en_o always shows register 0x30, the logical-device enable byte, and it is 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hardware reset, active low, asynchronous |
| strap_i | input | 1 | Base-select strap, followed during reset |
| aen_i | input | 1 | Address-enable qualifier; high blocks all decode |
| addr_i | input | 16 | I/O address |
| wr_i | input | 1 | I/O write strobe |
| rd_i | input | 1 | I/O read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0xFF when no decoded read |
| cfg_mode_o | output | 1 | Configuration mode active |
| ldev_en_o | output | 8 | Logical-device enable byte (register 0x30) |

## Verification
The bench drives an interrupted key (0x55, 0x11, 0x55). A detector that does not restart would unlock one write too early. Key writes made with aen_i high are also sent, and a decoder that ignores aen_i would count them. The lock write is sent with an index already set, and the index is then read back after the block is unlocked again. A design that loaded 0xAA into the index would return the wrong register. The test relocates the base and probes both the old and the new address, then resets with the opposite strap. A design that moved the base after the low-byte write, or kept the relocated base through reset, would answer at the wrong address.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int CFG_ADDR_W = 16;
  localparam logic [7:0] KEY_UNLOCK = 8'h55;
  localparam logic [7:0] KEY_LOCK   = 8'hAA;
  localparam logic [CFG_ADDR_W-1:0] BASE_STRAP0 = 16'h03F0;
  localparam logic [CFG_ADDR_W-1:0] BASE_STRAP1 = 16'h0370;
  localparam int IDX_BASE_LO = 'h26;
  localparam int IDX_BASE_HI = 'h27;
  localparam int IDX_LDEV_EN = 'h30;

  typedef enum logic [1:0] {
    KEY_IDLE = 2'd0,
    KEY_HALF = 2'd1,
    KEY_OPEN = 2'd2
  } key_state_e;
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec
  import cfg_port_pkg::*;
(
  input  logic [CFG_ADDR_W-1:0] addr_i,
  input  logic [CFG_ADDR_W-1:0] base_i,
  input  logic                  aen_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic                  cfg_mode_i,
  output logic                  hit_base_wr_o,
  output logic                  hit_data_wr_o,
  output logic                  hit_data_rd_o
);
  logic at_base, at_data;

  assign at_base = !aen_i && (addr_i == base_i);
  assign at_data = !aen_i && (addr_i == base_i + CFG_ADDR_W'(1));

  // base port is write-only; data port only live in config mode
  assign hit_base_wr_o = at_base && wr_i;
  assign hit_data_wr_o = at_data && wr_i && cfg_mode_i;
  assign hit_data_rd_o = at_data && rd_i && cfg_mode_i;
endmodule

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_base_wr_i,
  input  logic [7:0] wdata_i,
  output logic       cfg_mode_o,
  output logic       idx_wr_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (hit_base_wr_i) begin
      unique case (state_q)
        KEY_IDLE: state_d = (wdata_i == KEY_UNLOCK) ? KEY_HALF : KEY_IDLE;
        KEY_HALF: state_d = (wdata_i == KEY_UNLOCK) ? KEY_OPEN : KEY_IDLE;
        KEY_OPEN: state_d = (wdata_i == KEY_LOCK)   ? KEY_IDLE : KEY_OPEN;
        default:  state_d = KEY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KEY_IDLE;
    else         state_q <= state_d;
  end

  assign cfg_mode_o = (state_q == KEY_OPEN);
  assign idx_wr_o   = hit_base_wr_i && cfg_mode_o && (wdata_i != KEY_LOCK);

  p_unlock_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode_o) |-> $past(hit_base_wr_i && wdata_i == KEY_UNLOCK));

  p_lock_key_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_mode_o) |-> $past(hit_base_wr_i && wdata_i == KEY_LOCK));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  strap_i,
  input  logic                  idx_wr_i,
  input  logic                  data_wr_i,
  input  logic [7:0]            wdata_i,
  output logic [CFG_ADDR_W-1:0] base_o,
  output logic [7:0]            rd_val_o,
  output logic [7:0]            ldev_en_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [CFG_ADDR_W-1:0] strap_base, base_q;
  logic [7:0]            idx_q;
  logic [7:0]            regs_q [NUM_REGS];
  logic                  idx_ok;
  logic                  hi_wr;

  assign strap_base = strap_i ? BASE_STRAP1 : BASE_STRAP0;
  assign idx_ok     = 32'(idx_q) < NUM_REGS;
  assign hi_wr      = data_wr_i && (idx_q == 8'(IDX_BASE_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= 8'h00;
    else if (idx_wr_i) idx_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < NUM_REGS; g++) begin
        if (g == IDX_BASE_LO)      regs_q[g] <= strap_base[7:0];
        else if (g == IDX_BASE_HI) regs_q[g] <= strap_base[15:8];
        else                       regs_q[g] <= 8'h00;
      end
    end else if (data_wr_i && idx_ok) begin
      regs_q[idx_q[IDX_W-1:0]] <= wdata_i;
    end
  end

  // strap followed while reset held; value at release sticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    base_q <= strap_base;
    else if (hi_wr) base_q <= {wdata_i, regs_q[IDX_BASE_LO]};
  end

  assign base_o    = base_q;
  assign rd_val_o  = idx_ok ? regs_q[idx_q[IDX_W-1:0]] : 8'h00;
  assign ldev_en_o = regs_q[IDX_LDEV_EN];

  p_base_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(hi_wr)) |-> $stable(base_o));

  p_base_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr |=> (base_o[15:8] == $past(wdata_i)));
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  strap_i,
  input  logic                  aen_i,
  input  logic [CFG_ADDR_W-1:0] addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  output logic                  cfg_mode_o,
  output logic [7:0]            ldev_en_o
);
  logic [CFG_ADDR_W-1:0] base;
  logic hit_base_wr, hit_data_wr, hit_data_rd;
  logic idx_wr;
  logic [7:0] rd_val;

  cfg_addr_dec i_dec (
    .addr_i        (addr_i),
    .base_i        (base),
    .aen_i         (aen_i),
    .wr_i          (wr_i),
    .rd_i          (rd_i),
    .cfg_mode_i    (cfg_mode_o),
    .hit_base_wr_o (hit_base_wr),
    .hit_data_wr_o (hit_data_wr),
    .hit_data_rd_o (hit_data_rd)
  );

  cfg_key_fsm i_key (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hit_base_wr_i (hit_base_wr),
    .wdata_i       (wdata_i),
    .cfg_mode_o    (cfg_mode_o),
    .idx_wr_o      (idx_wr)
  );

  cfg_regfile #(.NUM_REGS(NUM_REGS)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_i   (strap_i),
    .idx_wr_i  (idx_wr),
    .data_wr_i (hit_data_wr),
    .wdata_i   (wdata_i),
    .base_o    (base),
    .rd_val_o  (rd_val),
    .ldev_en_o (ldev_en_o)
  );

  assign rdata_o = hit_data_rd ? rd_val : 8'hFF;

  p_aen_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |-> (rdata_o == 8'hFF));

  p_aen_no_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |=> $stable(cfg_mode_o));

  p_run_no_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_o |-> (rdata_o == 8'hFF));

  p_idle_ff_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == 8'hFF));
endmodule

// File: tb/test_cfg_port_ctrl.sv
module test_cfg_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        aen = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        cfg_mode;
  logic [7:0]  ldev_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cfg_port_ctrl i_cfg_port_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .aen_i(aen),
    .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .cfg_mode_o(cfg_mode), .ldev_en_o(ldev_en)
  );

  // behavioural reference
  int m_regs [256];
  int m_base, m_idx;
  bit m_cfg, m_half;

  task automatic model_reset();
    m_base = strap ? 'h370 : 'h3F0;
    foreach (m_regs[i]) m_regs[i] = 0;
    m_regs['h26] = m_base & 'hFF;
    m_regs['h27] = m_base >> 8;
    m_idx = 0; m_cfg = 0; m_half = 0;
  endtask

  function automatic int model_rdata();
    if (!aen && rd && m_cfg && int'(addr) == m_base + 1)
      return (m_idx < 64) ? m_regs[m_idx] : 0;
    return 'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit hb, hd;
      hb = !aen && wr && int'(addr) == m_base;
      hd = !aen && wr && m_cfg && int'(addr) == m_base + 1;
      if (hd && m_idx < 64) begin
        m_regs[m_idx] = int'(wdata);
        if (m_idx == 'h27) m_base = (int'(wdata) << 8) | m_regs['h26];
      end
      if (hb) begin
        if (!m_cfg) begin
          if (m_half) begin m_cfg = (wdata == 8'h55); m_half = 0; end
          else m_half = (wdata == 8'h55);
        end else if (wdata == 8'hAA) m_cfg = 0;
        else m_idx = int'(wdata);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(cfg_mode == m_cfg, "R2 model cfg_mode", int'(cfg_mode), int'(m_cfg));
      check(int'(rdata) == model_rdata(), "R9 model rdata", int'(rdata), model_rdata());
      check(int'(ldev_en) == m_regs['h30], "R12 model ldev_en", int'(ldev_en), m_regs['h30]);
    end
  end

  task automatic bus_wr(int a, int d, bit e = 1'b0);
    @(negedge clk);
    addr = 16'(a); wdata = 8'(d); wr = 1'b1; aen = e;
    @(negedge clk);
    wr = 1'b0; aen = 1'b0;
  endtask

  task automatic bus_rd(int a, output int d);
    @(negedge clk);
    addr = 16'(a); rd = 1'b1;
    #1 d = int'(rdata);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_reset(bit s);
    @(negedge clk);
    strap = s; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    do_reset(1'b0);
    check(cfg_mode == 1'b0, "R1 run mode after reset", int'(cfg_mode), 0);
    check(ldev_en == 8'h00, "R12 enables clear", int'(ldev_en), 0);
    bus_rd('h3F1, v);
    check(v == 'hFF, "R7 data read in run mode", v, 'hFF);
    bus_wr('h3F1, 'h5A);              // R7 ignored write, idx 0
    bus_wr('h3F0, 'h55); bus_wr('h3F0, 'h11); bus_wr('h3F0, 'h55);
    check(cfg_mode == 1'b0, "R3 interrupted key", int'(cfg_mode), 0);
    bus_wr('h3F0, 'h55);
    check(cfg_mode == 1'b1, "R2 unlock", int'(cfg_mode), 1);
    bus_rd('h3F1, v);
    check(v == 'h00, "R7 run-mode write dropped, reg0", v, 0);
    bus_rd('h3F0, v);
    check(v == 'hFF, "R9 base port not readable", v, 'hFF);
    bus_wr('h3F0, 'h26); bus_rd('h3F1, v);
    check(v == 'hF0, "R1 strap0 base low byte", v, 'hF0);
    bus_wr('h3F0, 'h27); bus_rd('h3F1, v);
    check(v == 'h03, "R1 strap0 base high byte", v, 'h03);
    bus_wr('h3F0, 'h30); bus_wr('h3F1, 'hA5); bus_rd('h3F1, v);
    check(v == 'hA5, "R6 data readback", v, 'hA5);
    check(ldev_en == 8'hA5, "R12 enable byte follows reg", int'(ldev_en), 'hA5);
    bus_wr('h3F0, 'h50); bus_wr('h3F1, 'h77); bus_rd('h3F1, v);
    check(v == 'h00, "R6 index out of range", v, 0);
    bus_wr('h3F0, 'h30);              // R5 index load
    bus_wr('h3F0, 'hAA);
    check(cfg_mode == 1'b0, "R4 lock", int'(cfg_mode), 0);
    bus_wr('h3F0, 'h12);              // R7 must not touch index
    bus_wr('h3F0, 'h55, 1'b1); bus_wr('h3F0, 'h55);
    check(cfg_mode == 1'b0, "R8 aen-qualified key ignored", int'(cfg_mode), 0);
    bus_wr('h3F0, 'h55);
    check(cfg_mode == 1'b1, "R8 relock after aen", int'(cfg_mode), 1);
    bus_rd('h3F1, v);
    check(v == 'hA5, "R4 index kept across lock", v, 'hA5);
    aen = 1'b1; bus_rd('h3F1, v); aen = 1'b0;
    check(v == 'hFF, "R8 aen blocks read", v, 'hFF);
    bus_wr('h3F0, 'h26); bus_wr('h3F1, 'h80);
    bus_rd('h3F1, v);
    check(v == 'h80, "R10 old base until high byte", v, 'h80);
    bus_wr('h3F0, 'h27); bus_wr('h3F1, 'h02);
    bus_rd('h3F1, v);
    check(v == 'hFF, "R10 old base dead", v, 'hFF);
    bus_rd('h281, v);
    check(v == 'h02, "R10 new base live", v, 'h02);
    bus_wr('h280, 'hAA);
    check(cfg_mode == 1'b0, "R10 lock at new base", int'(cfg_mode), 0);
    bus_wr('h280, 'h55); bus_wr('h280, 'h55);
    check(cfg_mode == 1'b1, "R11 relocated base kept", int'(cfg_mode), 1);
    do_reset(1'b1);
    check(cfg_mode == 1'b0, "R11 reset to run mode", int'(cfg_mode), 0);
    bus_wr('h280, 'h55); bus_wr('h280, 'h55);
    check(cfg_mode == 1'b0, "R11 relocation cleared", int'(cfg_mode), 0);
    bus_wr('h370, 'h55); bus_wr('h370, 'h55);
    check(cfg_mode == 1'b1, "R11 strap1 base", int'(cfg_mode), 1);
    bus_wr('h370, 'h26); bus_rd('h371, v);
    check(v == 'h70, "R1 strap1 base low byte", v, 'h70);
    check(ldev_en == 8'h00, "R12 enables cleared by reset", int'(ldev_en), 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule